// File: doc/BRIEF.md
# Privilege-Based Hit/Miss Detector

This block is the decision stage of a multi-threaded data cache pipeline. Each cycle it may receive one registered load or store request together with the stored tags of every way in the addressed set and two privilege bits per way: a read permission and a write permission. It decides whether the access hits. A load needs a tag match on a way whose read permission is set. A store needs a tag match on a way whose write permission is set.

On a hit the block outputs a one-hot way select for the data array. On a miss it raises a miss event. That event returns the request's thread, address and kind so the request can be placed back in the thread's replay slot. In the same cycle it sends a per-thread sleep mask to the instruction buffer, which parks the issuing thread. Flush and eviction notices from the stage before are registered and passed on to the cache controller as separate events. These events may coincide with a hit or a miss.

All results appear exactly one clock after the inputs that cause them.

Top module: `hitmiss_detect`

## Requirements
- R1: A load (store flag 0) hits when exactly one way's tag equals the top TAG_W bits of the request address and that way's read permission is 1. One cycle later `hitValid` is 1, `hitWayOh` has only that way's bit set (bit w = way w), and `respThread` is the request thread.
- R2: A store (store flag 1) hits only when the matching way's write permission is 1, whatever its read permission.
- R3: A store whose matching way is readable but not writable is reported as a miss, not a hit.
- R4: A request with no tag match is a miss. So is a load whose matching way has read permission 0.
- R5: For a missing request, `missValid` is 1 for exactly one cycle, one cycle after the request.
- R6: In the same cycle as `missValid`, `sleepMask` has exactly one bit set, at the index of the request thread. In all other cycles it is zero.
- R7: With `missValid`, the outputs `respThread`, `respAddr` and `respStore` return the missing request's thread, address and store flag for replay.
- R8: `hitValid` and `missValid` are never 1 together. Neither is 1 in the cycle after a cycle with `reqValid` low.
- R9: `flushEvt` follows `flushValid` one cycle later, and `flushEvtAddr` then carries that cycle's `flushAddr`.
- R10: `evictEvt` follows `evictValid` one cycle later with `evictEvtAddr`, independent of the flush event and of any hit or miss in the same cycle.
- R11: While reset is asserted, every valid output and `sleepMask` is 0.
- R12: `hitWayOh` is zero in every cycle in which `hitValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqThread | input | TID_W | Issuing thread |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Request address; top TAG_W bits are the tag |
| wayTags | input | WAYS*TAG_W | Stored tags, way w in bits [w*TAG_W +: TAG_W] |
| wayCanRead | input | WAYS | Read permission per way |
| wayCanWrite | input | WAYS | Write permission per way |
| flushValid | input | 1 | Flush notice present |
| flushAddr | input | ADDR_W | Flush line address |
| evictValid | input | 1 | Eviction/update notice present |
| evictAddr | input | ADDR_W | Evicted line address |
| hitValid | output | 1 | Request hit |
| hitWayOh | output | WAYS | One-hot hitting way |
| missValid | output | 1 | Miss event and replay push |
| sleepMask | output | THREADS | One-hot thread to park |
| respThread | output | TID_W | Thread of the resolved request |
| respAddr | output | ADDR_W | Address of the resolved request |
| respStore | output | 1 | Store flag of the resolved request |
| flushEvt | output | 1 | Flush event to controller |
| flushEvtAddr | output | ADDR_W | Flush event address |
| evictEvt | output | 1 | Eviction event to controller |
| evictEvtAddr | output | ADDR_W | Eviction event address |

## Verification
A miss and an eviction (or flush) notice can land in the same cycle. The events then leave on separate outputs together with the sleep pulse, and no address may bleed between them. The bench provokes this by driving random flush and eviction notices with distinct addresses alongside random requests, in both hitting and missing patterns. A behavioural model predicts every output for the following cycle, and each event and its address payload is judged on its own in every cycle.

// File: rtl/hitmiss_pkg.sv
package hitmiss_pkg;
  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic hitNow;
    logic missNow;
    logic flushNow;
    logic evictNow;
  } ctlStrobes_t;
endpackage

// File: rtl/hitmiss_ctrl.sv
module hitmiss_ctrl
  import hitmiss_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [WAYS-1:0] wayOk,
  input  logic            flushValid,
  input  logic            evictValid,
  output ctlStrobes_t     strobes,
  output logic            hitValid,
  output logic            missValid,
  output logic            flushEvt,
  output logic            evictEvt
);
  always_comb begin
    strobes.hitNow   = reqValid && (|wayOk);
    strobes.missNow  = reqValid && !(|wayOk);
    strobes.flushNow = flushValid;
    strobes.evictNow = evictValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValid  <= 1'b0;
      missValid <= 1'b0;
      flushEvt  <= 1'b0;
      evictEvt  <= 1'b0;
    end else begin
      hitValid  <= strobes.hitNow;
      missValid <= strobes.missNow;
      flushEvt  <= strobes.flushNow;
      evictEvt  <= strobes.evictNow;
    end
  end

  // R8
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(hitValid || missValid));
  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hitValid && missValid));
  // R9
  flush_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> flushEvt);
  // R10
  evict_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |=> evictEvt);
endmodule

// File: rtl/hitmiss_dpath.sv
module hitmiss_dpath
  import hitmiss_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 12,
  parameter int ADDR_W  = 20,
  parameter int THREADS = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [TID_W-1:0]      reqThread,
  input  logic                  reqStore,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WAYS*TAG_W-1:0] wayTags,
  input  logic [WAYS-1:0]       wayCanRead,
  input  logic [WAYS-1:0]       wayCanWrite,
  input  logic [ADDR_W-1:0]     flushAddr,
  input  logic [ADDR_W-1:0]     evictAddr,
  input  ctlStrobes_t           strobes,
  output logic [WAYS-1:0]       wayOk,
  output logic [WAYS-1:0]       hitWayOh,
  output logic [THREADS-1:0]    sleepMask,
  output logic [TID_W-1:0]      respThread,
  output logic [ADDR_W-1:0]     respAddr,
  output logic                  respStore,
  output logic [ADDR_W-1:0]     flushEvtAddr,
  output logic [ADDR_W-1:0]     evictEvtAddr
);
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  tagMatch;

  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tagMatch[w] = (wayTags[w*TAG_W +: TAG_W] == reqTag);
    assign wayOk[w]    = tagMatch[w] && (reqStore ? wayCanWrite[w] : wayCanRead[w]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitWayOh  <= '0;
      sleepMask <= '0;
    end else begin
      hitWayOh  <= strobes.hitNow ? wayOk : '0;
      sleepMask <= strobes.missNow ? (THREADS'(1) << reqThread) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respThread   <= '0;
      respAddr     <= '0;
      respStore    <= 1'b0;
      flushEvtAddr <= '0;
      evictEvtAddr <= '0;
    end else begin
      if (strobes.hitNow || strobes.missNow) begin
        respThread <= reqThread;
        respAddr   <= reqAddr;
        respStore  <= reqStore;
      end
      if (strobes.flushNow) flushEvtAddr <= flushAddr;
      if (strobes.evictNow) evictEvtAddr <= evictAddr;
    end
  end

  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0(tagMatch));
endmodule

// File: rtl/hitmiss_detect.sv
module hitmiss_detect
  import hitmiss_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 12,
  parameter int ADDR_W  = 20,
  parameter int THREADS = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [TID_W-1:0]      reqThread,
  input  logic                  reqStore,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WAYS*TAG_W-1:0] wayTags,
  input  logic [WAYS-1:0]       wayCanRead,
  input  logic [WAYS-1:0]       wayCanWrite,
  input  logic                  flushValid,
  input  logic [ADDR_W-1:0]     flushAddr,
  input  logic                  evictValid,
  input  logic [ADDR_W-1:0]     evictAddr,
  output logic                  hitValid,
  output logic [WAYS-1:0]       hitWayOh,
  output logic                  missValid,
  output logic [THREADS-1:0]    sleepMask,
  output logic [TID_W-1:0]      respThread,
  output logic [ADDR_W-1:0]     respAddr,
  output logic                  respStore,
  output logic                  flushEvt,
  output logic [ADDR_W-1:0]     flushEvtAddr,
  output logic                  evictEvt,
  output logic [ADDR_W-1:0]     evictEvtAddr
);
  ctlStrobes_t     strobes;
  logic [WAYS-1:0] wayOk;

  hitmiss_ctrl #(.WAYS(WAYS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wayOk(wayOk),
    .flushValid(flushValid), .evictValid(evictValid), .strobes(strobes),
    .hitValid(hitValid), .missValid(missValid),
    .flushEvt(flushEvt), .evictEvt(evictEvt)
  );

  hitmiss_dpath #(.WAYS(WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .THREADS(THREADS)) u_dpath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqStore(reqStore), .reqAddr(reqAddr), .wayTags(wayTags),
    .wayCanRead(wayCanRead), .wayCanWrite(wayCanWrite),
    .flushAddr(flushAddr), .evictAddr(evictAddr), .strobes(strobes),
    .wayOk(wayOk), .hitWayOh(hitWayOh), .sleepMask(sleepMask),
    .respThread(respThread), .respAddr(respAddr), .respStore(respStore),
    .flushEvtAddr(flushEvtAddr), .evictEvtAddr(evictEvtAddr)
  );

  // R1
  hit_way_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $onehot(hitWayOh));
  // R12
  no_way_without_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitWayOh == '0));
  // R6
  sleep_with_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> ($countones(sleepMask) == 1));
  // R6
  sleep_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !missValid |-> (sleepMask == '0));
endmodule

// File: tb/tb_hitmiss_detect.sv
module tb_hitmiss_detect;
  localparam int WAYS = 4, TAG_W = 12, ADDR_W = 20, THREADS = 8, TID_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqStore = 0, flushValid = 0, evictValid = 0;
  logic [TID_W-1:0] reqThread = '0;
  logic [ADDR_W-1:0] reqAddr = '0, flushAddr = '0, evictAddr = '0;
  logic [WAYS*TAG_W-1:0] wayTags = '0;
  logic [WAYS-1:0] wayCanRead = '0, wayCanWrite = '0;
  logic hitValid, missValid, respStore, flushEvt, evictEvt;
  logic [WAYS-1:0] hitWayOh;
  logic [THREADS-1:0] sleepMask;
  logic [TID_W-1:0] respThread;
  logic [ADDR_W-1:0] respAddr, flushEvtAddr, evictEvtAddr;

  hitmiss_detect dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit haveExp = 0;
  // expected values for the next compare
  bit eHit, eMiss, eFl, eEv, eRdOnlyStore;
  int eWay, eThr, eStore, eAddr, eFlAddr, eEvAddr;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    string hr;
    hr = eMiss ? (eRdOnlyStore ? "R3" : "R4") : (eStore != 0 ? "R2" : "R1");
    chk(hr, hitValid, eHit);
    chk("R5", missValid, eMiss);
    chk("R8", hitValid & missValid, 0);
    chk("R12", hitWayOh, eHit ? (1 << eWay) : 0);
    chk("R6", sleepMask, eMiss ? (1 << eThr) : 0);
    if (eHit) chk("R1", respThread, eThr);
    if (eMiss) begin
      chk("R7", respThread, eThr);
      chk("R7", respAddr, eAddr);
      chk("R7", respStore, eStore);
    end
    chk("R9", flushEvt, eFl);
    if (eFl) chk("R9", flushEvtAddr, eFlAddr);
    chk("R10", evictEvt, eEv);
    if (eEv) chk("R10", evictEvtAddr, eEvAddr);
  endtask

  // model: compute expectation from current inputs
  task automatic predict();
    int mw;
    logic [TAG_W-1:0] t;
    mw = -1;
    t = reqAddr[ADDR_W-1 -: TAG_W];
    for (int w = 0; w < WAYS; w++)
      if (wayTags[w*TAG_W +: TAG_W] == t) mw = w;
    eHit = 0;
    eRdOnlyStore = 0;
    if (reqValid && mw >= 0) begin
      if (reqStore) eHit = wayCanWrite[mw];
      else          eHit = wayCanRead[mw];
      eRdOnlyStore = reqStore && wayCanRead[mw] && !wayCanWrite[mw];
    end
    eMiss = reqValid && !eHit;
    eWay = mw; eThr = reqThread; eStore = reqStore; eAddr = reqAddr;
    eFl = flushValid; eEv = evictValid;
    eFlAddr = flushAddr; eEvAddr = evictAddr;
  endtask

  // drive one cycle: matchWay<0 means no tag matches
  task automatic drive(bit v, int thr, bit st, int matchWay, int rd, int wr,
                       bit fl, bit ev);
    logic [TAG_W-1:0] base;
    base = TAG_W'($urandom);
    for (int w = 0; w < WAYS; w++)
      wayTags[w*TAG_W +: TAG_W] = base + TAG_W'(w * 7);
    reqAddr = {(matchWay >= 0) ? base + TAG_W'(matchWay * 7) : base + TAG_W'(3),
               (ADDR_W-TAG_W)'($urandom)};
    reqValid = v; reqThread = TID_W'(thr); reqStore = st;
    wayCanRead = WAYS'(rd); wayCanWrite = WAYS'(wr);
    flushValid = fl; flushAddr = ADDR_W'($urandom);
    evictValid = ev; evictAddr = ADDR_W'($urandom);
  endtask

  task automatic step(bit v, int thr, bit st, int mw, int rd, int wr, bit fl, bit ev);
    @(negedge clk);
    if (haveExp) compare();
    drive(v, thr, st, mw, rd, wr, fl, ev);
    predict();
    haveExp = 1;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state, R11
    drive(1, 2, 0, 1, 4'hF, 4'hF, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", {hitValid, missValid, flushEvt, evictEvt}, 0);
    chk("R11", sleepMask, 0);
    rstN = 1;
    reqValid = 0; flushValid = 0; evictValid = 0;
    // directed cases
    step(1, 1, 0, 2, 4'b0100, 4'b0000, 0, 0);  // R1 load hit way2
    step(1, 5, 1, 0, 4'b0000, 4'b0001, 0, 0);  // R2 store hit way0
    step(1, 6, 1, 3, 4'b1000, 4'b0000, 0, 0);  // R3 readable-only store
    step(1, 7, 0, -1, 4'hF, 4'hF, 0, 0);       // R4 no match
    step(1, 0, 0, 1, 4'b0000, 4'b0010, 0, 0);  // R4 load, no read perm
    step(0, 3, 0, 1, 4'hF, 4'hF, 1, 0);        // R8 idle + R9 flush
    step(1, 4, 0, -1, 4'h0, 4'h0, 0, 1);       // R10 evict with miss
    step(1, 2, 1, -1, 4'h0, 4'h0, 1, 1);       // miss + flush + evict
    step(1, 3, 1, 3, 4'b0000, 4'b1000, 1, 1);  // hit + both events
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, $urandom % THREADS, $urandom % 2,
           int'($urandom % (WAYS + 1)) - 1, $urandom % 16, $urandom % 16,
           ($urandom % 3) == 0, ($urandom % 3) == 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule